// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block watches every bus access a processor core makes and compares it against four programmable breakpoints. Each breakpoint has a 32-bit address register and a 4-bit field in a shared control register. The field selects the kind of access it reacts to (instruction fetch, data write, data read or write, or I/O port access) and how many low address bits are masked. When an enabled breakpoint matches, the unit records the matching breakpoints in a sticky status register. It then raises a one-cycle debug-exception request, carrying vector 1 and the mask of breakpoints that caused it.

Reporting is precise. An ordinary access that matches produces its request in the very next cycle and is tied to that access alone. During a repeated string operation a match is held back until the core reports that the current iteration has finished. The request then goes out before the next iteration can begin. Matches from the same iteration are merged into that one request. I/O breakpoints act only while the extension-enable input is high. The port number is taken from the low 16 address bits and zero-extended before comparison.

The reporting logic is a three-state machine. IDLE means nothing is outstanding. PEND means a string-iteration hit is waiting for the iteration to end. FIRE is the single cycle in which the request is driven. The transitions are:
- IDLE or FIRE go to FIRE on a hit outside a string iteration, or on a hit in the cycle its iteration ends.
- IDLE or FIRE go to PEND on a hit inside an iteration that has not yet finished.
- PEND stays in PEND, merging new hits, while the iteration runs.
- PEND goes to FIRE when the iteration-done strobe arrives.
- FIRE goes to IDLE when there is no new hit.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset, all four address registers, the control register and the status register read 0, and `dbg_req` and `hit_mask` are 0.
- R2: Register offsets on `reg_addr` are fixed: 0 to 3 are the breakpoint address registers, 4 is the control register and 5 is the status register. A write with `reg_wr` high takes effect at the clock edge. `reg_rdata` shows the addressed register in the same cycle, and unused offsets read 0.
- R3: Control bit 2i is the local enable and bit 2i+1 is the global enable of breakpoint i. A breakpoint can match only when at least one of the two is 1.
- R4: Control bits [16+4i +: 2] hold the type of breakpoint i. Type 2'b00 matches only instruction fetches (`acc_kind` 0), and it compares all 32 address bits regardless of length.
- R5: Type 2'b01 matches only memory data writes (`acc_kind` 2). Type 2'b11 matches memory data reads (`acc_kind` 1) or writes.
- R6: Control bits [18+4i +: 2] hold the length of breakpoint i. For data and I/O types, length 2'b00 compares all bits, 2'b01 ignores address bit 0, and 2'b10 or 2'b11 ignore bits 1:0.
- R7: Type 2'b10 matches I/O reads or writes (`acc_kind` 3 or 4), but only while `io_ext_en` is 1. With `io_ext_en` at 0 it never matches, and I/O accesses never match the memory types.
- R8: For I/O accesses the compared address is the low 16 bits of `acc_addr`, zero-extended to 32 bits. The upper bits of `acc_addr` are ignored.
- R9: A matching access with `acc_rep` at 0 raises `dbg_req` for exactly one cycle, the cycle after the access. `hit_mask` then equals the set of breakpoints that matched, and `dbg_vector` reads 1. With no match, `dbg_req` stays 0.
- R10: When several breakpoints match one access, all of their bits appear together in one request.
- R11: A match while `acc_rep` is 1 and `acc_iter_done` is 0 raises no request. The request appears the cycle after `acc_iter_done` is 1, carrying the union of all hits since the iteration began. A match in the same cycle as `acc_iter_done` is reported the next cycle.
- R12: Status bits 3:0 are set, together with the request, for every breakpoint in `hit_mask`. Only a software write to offset 5 changes them otherwise. Such a write loads the written value, and hits reported at the same edge are ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| io_ext_en | input | 1 | I/O breakpoint extension enable |
| acc_valid | input | 1 | A bus access is presented this cycle |
| acc_kind | input | 3 | 0 fetch, 1 data read, 2 data write, 3 I/O read, 4 I/O write |
| acc_addr | input | 32 | Access address, or port number in low 16 bits |
| acc_rep | input | 1 | Access belongs to a repeated string iteration |
| acc_iter_done | input | 1 | The current string iteration completes this cycle |
| dbg_req | output | 1 | One-cycle debug-exception request |
| dbg_vector | output | 8 | Exception vector number for the request (1) |
| hit_mask | output | 4 | Breakpoints that caused the request |

## Verification
The hardest situation to reach from the ports is a deferred string-iteration hit that merges with a second hit before the iteration ends. The stimulus needs a matching access with `acc_rep` held high, then idle cycles with the done strobe low, then a second matching access of another type, and only then the done strobe. The bench builds exactly this sequence. It checks that `dbg_req` stays low throughout and that the final request carries both breakpoints. A table of single accesses covers type, length and port-extension decoding, including an I/O access with junk in the upper address bits.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int NUM_BP    = 4;
    localparam int ADDR_W    = 32;
    localparam int PORT_W    = 16;
    localparam int REG_AW    = 3;
    localparam int FIELD_LSB = 16;
    localparam int FIELD_W   = 4;

    localparam logic [REG_AW-1:0] REG_CTRL = 3'd4;
    localparam logic [REG_AW-1:0] REG_STAT = 3'd5;

    localparam logic [7:0] DBG_VECTOR = 8'd1;

    typedef enum logic [2:0] {
        ACC_FETCH = 3'd0,
        ACC_MRD   = 3'd1,
        ACC_MWR   = 3'd2,
        ACC_IORD  = 3'd3,
        ACC_IOWR  = 3'd4
    } acc_kind_t;

    typedef enum logic [1:0] {
        BT_EXEC  = 2'b00,
        BT_WRITE = 2'b01,
        BT_IO    = 2'b10,
        BT_RDWR  = 2'b11
    } bp_type_t;

    typedef enum logic [1:0] {
        RPT_IDLE = 2'd0,
        RPT_PEND = 2'd1,
        RPT_FIRE = 2'd2
    } rpt_state_t;

endpackage

// File: rtl/bkpt_comparator.sv
module bkpt_comparator
    import bkpt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PORT_W
) (
    input  logic [AW-1:0] bp_addr,
    input  logic [1:0]    bp_type,
    input  logic [1:0]    bp_len,
    input  logic          bp_enable,
    input  logic          io_ext_en,
    input  logic          acc_valid,
    input  logic [2:0]    acc_kind,
    input  logic [AW-1:0] acc_addr,
    output logic          hit
);

    logic          is_io;
    logic          is_rd;
    logic          is_wr;
    logic          is_fetch;
    logic [AW-1:0] eff_addr;
    logic [AW-1:0] low_mask;
    logic          eq_full;
    logic          eq_masked;
    logic          kind_ok;
    logic          addr_ok;

    always_comb begin
        is_fetch = (acc_kind == ACC_FETCH);
        is_rd    = (acc_kind == ACC_MRD);
        is_wr    = (acc_kind == ACC_MWR);
        is_io    = (acc_kind == ACC_IORD) || (acc_kind == ACC_IOWR);

        if (is_io) begin
            eff_addr = {{(AW-PW){1'b0}}, acc_addr[PW-1:0]};
        end else begin
            eff_addr = acc_addr;
        end

        unique case (bp_len)
            2'b00:   low_mask = {AW{1'b1}};
            2'b01:   low_mask = {{(AW-1){1'b1}}, 1'b0};
            default: low_mask = {{(AW-2){1'b1}}, 2'b00};
        endcase

        eq_full   = (eff_addr == bp_addr);
        eq_masked = (((eff_addr ^ bp_addr) & low_mask) == '0);

        unique case (bp_type_t'(bp_type))
            BT_EXEC: begin
                kind_ok = is_fetch;
                addr_ok = eq_full;
            end
            BT_WRITE: begin
                kind_ok = is_wr;
                addr_ok = eq_masked;
            end
            BT_IO: begin
                kind_ok = is_io && io_ext_en;
                addr_ok = eq_masked;
            end
            default: begin
                kind_ok = is_rd || is_wr;
                addr_ok = eq_masked;
            end
        endcase

        hit = acc_valid && bp_enable && kind_ok && addr_ok;
    end

endmodule

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
    import bkpt_pkg::*;
#(
    parameter int NB = NUM_BP,
    parameter int AW = ADDR_W,
    parameter int RW = REG_AW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [RW-1:0]         reg_addr,
    input  logic [AW-1:0]         reg_wdata,
    output logic [AW-1:0]         reg_rdata,
    input  logic                  fire,
    input  logic [NB-1:0]         fire_mask,
    output logic [NB-1:0][AW-1:0] bp_addr_o,
    output logic [NB-1:0][1:0]    bp_type_o,
    output logic [NB-1:0][1:0]    bp_len_o,
    output logic [NB-1:0]         bp_en_o,
    output logic [NB-1:0]         status_o
);

    logic [NB-1:0][AW-1:0] addr_q;
    logic [AW-1:0]         ctrl_q;
    logic [NB-1:0]         stat_q;
    logic [NB-1:0]         stat_d;

    for (genvar i = 0; i < NB; i++) begin : g_addr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q[i] <= '0;
            end else if (reg_wr && (reg_addr == RW'(i))) begin
                addr_q[i] <= reg_wdata;
            end
        end

        assign bp_en_o[i]   = ctrl_q[2*i] | ctrl_q[2*i+1];
        assign bp_type_o[i] = ctrl_q[FIELD_LSB + FIELD_W*i +: 2];
        assign bp_len_o[i]  = ctrl_q[FIELD_LSB + FIELD_W*i + 2 +: 2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr && (reg_addr == REG_CTRL)) begin
            ctrl_q <= reg_wdata;
        end
    end

    always_comb begin
        stat_d = stat_q;
        if (reg_wr && (reg_addr == REG_STAT)) begin
            stat_d = reg_wdata[NB-1:0];
        end
        if (fire) begin
            stat_d = stat_d | fire_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NB; k++) begin
            if (reg_addr == RW'(k)) begin
                reg_rdata = addr_q[k];
            end
        end
        if (reg_addr == REG_CTRL) begin
            reg_rdata = ctrl_q;
        end
        if (reg_addr == REG_STAT) begin
            reg_rdata = {{(AW-NB){1'b0}}, stat_q};
        end
    end

    assign bp_addr_o = addr_q;
    assign status_o  = stat_q;

endmodule

// File: rtl/bkpt_report_fsm.sv
module bkpt_report_fsm
    import bkpt_pkg::*;
#(
    parameter int NB = NUM_BP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] hits,
    input  logic          acc_rep,
    input  logic          acc_iter_done,
    output logic          fire,
    output logic [NB-1:0] fire_mask,
    output logic          dbg_req,
    output logic [NB-1:0] hit_mask,
    output rpt_state_t    state_o
);

    rpt_state_t    state_q;
    rpt_state_t    state_d;
    logic [NB-1:0] pend_q;
    logic [NB-1:0] pend_d;
    logic [NB-1:0] mask_q;
    logic [NB-1:0] mask_d;
    logic [NB-1:0] merged;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RPT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = RPT_IDLE;
        pend_d  = pend_q;
        mask_d  = '0;
        merged  = pend_q | hits;
        unique case (state_q)
            RPT_IDLE, RPT_FIRE: begin
                pend_d = '0;
                if (|hits) begin
                    if (acc_rep && !acc_iter_done) begin
                        state_d = RPT_PEND;
                        pend_d  = hits;
                    end else begin
                        state_d = RPT_FIRE;
                        mask_d  = hits;
                    end
                end
            end
            RPT_PEND: begin
                if (acc_iter_done) begin
                    state_d = RPT_FIRE;
                    mask_d  = merged;
                    pend_d  = '0;
                end else begin
                    state_d = RPT_PEND;
                    pend_d  = merged;
                end
            end
            default: begin
                state_d = RPT_IDLE;
                pend_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= pend_d;
            mask_q <= mask_d;
        end
    end

    assign fire      = (state_d == RPT_FIRE);
    assign fire_mask = mask_d;
    assign dbg_req   = (state_q == RPT_FIRE);
    assign hit_mask  = mask_q;
    assign state_o   = state_q;

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              io_ext_en,
    input  logic              acc_valid,
    input  logic [2:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_rep,
    input  logic              acc_iter_done,
    output logic              dbg_req,
    output logic [7:0]        dbg_vector,
    output logic [NUM_BP-1:0] hit_mask
);

    logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr;
    logic [NUM_BP-1:0][1:0]        bp_type;
    logic [NUM_BP-1:0][1:0]        bp_len;
    logic [NUM_BP-1:0]             bp_en;
    logic [NUM_BP-1:0]             status_bits;
    logic [NUM_BP-1:0]             hits;
    logic                          fire;
    logic [NUM_BP-1:0]             fire_mask;
    rpt_state_t                    rpt_state;

    bkpt_regfile #(
        .NB (NUM_BP),
        .AW (ADDR_W),
        .RW (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fire      (fire),
        .fire_mask (fire_mask),
        .bp_addr_o (bp_addr),
        .bp_type_o (bp_type),
        .bp_len_o  (bp_len),
        .bp_en_o   (bp_en),
        .status_o  (status_bits)
    );

    for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
        bkpt_comparator #(
            .AW (ADDR_W),
            .PW (PORT_W)
        ) u_cmp (
            .bp_addr   (bp_addr[i]),
            .bp_type   (bp_type[i]),
            .bp_len    (bp_len[i]),
            .bp_enable (bp_en[i]),
            .io_ext_en (io_ext_en),
            .acc_valid (acc_valid),
            .acc_kind  (acc_kind),
            .acc_addr  (acc_addr),
            .hit       (hits[i])
        );
    end

    bkpt_report_fsm #(
        .NB (NUM_BP)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hits          (hits),
        .acc_rep       (acc_rep),
        .acc_iter_done (acc_iter_done),
        .fire          (fire),
        .fire_mask     (fire_mask),
        .dbg_req       (dbg_req),
        .hit_mask      (hit_mask),
        .state_o       (rpt_state)
    );

    assign dbg_vector = dbg_req ? DBG_VECTOR : 8'd0;

endmodule

// File: rtl/bkpt_match_unit_chk.sv
module bkpt_match_unit_chk
    import bkpt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic              io_ext_en,
    input logic              acc_valid,
    input logic [2:0]        acc_kind,
    input logic              acc_iter_done,
    input logic              dbg_req,
    input logic [7:0]        dbg_vector,
    input logic [NUM_BP-1:0] hit_mask,
    input logic [NUM_BP-1:0] status_bits,
    input rpt_state_t        rpt_state
);

    assert_req_has_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> (hit_mask != '0) && (dbg_vector == 8'd1));

    assert_no_req_uncaused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && rpt_state != RPT_PEND) |=> !dbg_req);

    assert_status_holds_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> ((status_bits & hit_mask) == hit_mask));

    assert_status_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == REG_STAT) |=>
            ((status_bits & $past(status_bits)) == $past(status_bits)));

    assert_pend_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_state == RPT_PEND && !acc_iter_done) |=> !dbg_req);

    assert_io_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !io_ext_en && rpt_state != RPT_PEND &&
         (acc_kind == ACC_IORD || acc_kind == ACC_IOWR)) |=> !dbg_req);

endmodule

bind bkpt_match_unit bkpt_match_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .io_ext_en     (io_ext_en),
    .acc_valid     (acc_valid),
    .acc_kind      (acc_kind),
    .acc_iter_done (acc_iter_done),
    .dbg_req       (dbg_req),
    .dbg_vector    (dbg_vector),
    .hit_mask      (hit_mask),
    .status_bits   (status_bits),
    .rpt_state     (rpt_state)
);

// File: tb/bkpt_match_unit_tb.sv
`timescale 1ns/1ps
module bkpt_match_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        io_ext_en = 1'b0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_kind = '0;
    logic [31:0] acc_addr = '0;
    logic        acc_rep = 1'b0;
    logic        acc_iter_done = 1'b0;
    logic        dbg_req;
    logic [7:0]  dbg_vector;
    logic [3:0]  hit_mask;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bkpt_match_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_ext_en(io_ext_en),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
        .acc_rep(acc_rep), .acc_iter_done(acc_iter_done), .dbg_req(dbg_req),
        .dbg_vector(dbg_vector), .hit_mask(hit_mask)
    );

    // {kind[2:0], addr[31:0], io_ext_en, expected mask[3:0]}
    localparam int NVEC = 12;
    localparam logic [39:0] VEC [NVEC] = '{
        {3'd0, 32'h0000_1000, 1'b1, 4'b0001},  // R4 fetch exact
        {3'd0, 32'h0000_1001, 1'b1, 4'b0000},  // R4 full compare
        {3'd1, 32'h0000_1000, 1'b1, 4'b0000},  // R4 read not a fetch
        {3'd2, 32'h2000_0007, 1'b1, 4'b1010},  // R5 R6 R10 two hits
        {3'd1, 32'h2000_0005, 1'b1, 4'b0000},  // R5 R6 read misses
        {3'd1, 32'h2000_0006, 1'b1, 4'b1000},  // R5 read on rd/wr type
        {3'd3, 32'h0000_0080, 1'b1, 4'b0100},  // R7 io read
        {3'd4, 32'h0000_0080, 1'b0, 4'b0000},  // R7 extension off
        {3'd4, 32'hABCD_0080, 1'b1, 4'b0100},  // R8 upper bits ignored
        {3'd0, 32'h2000_0004, 1'b1, 4'b0000},  // R5 fetch on write type
        {3'd2, 32'h0000_0080, 1'b1, 4'b0000},  // R7 memory on io type
        {3'd3, 32'h0000_1000, 1'b1, 4'b0000}   // R7 io on fetch type
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // present one access; return at next negedge with outputs valid
    task automatic access(input logic [2:0] k, input logic [31:0] a, input logic ext,
                          input logic rep, input logic done);
        acc_valid = 1'b1; acc_kind = k; acc_addr = a; io_ext_en = ext;
        acc_rep = rep; acc_iter_done = done;
        @(negedge clk);
        acc_valid = 1'b0; acc_iter_done = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 dbg_req", {31'd0, dbg_req}, 32'd0);
        chk("R1 hit_mask", {28'd0, hit_mask}, 32'd0);
        for (int r = 0; r < 6; r++) begin
            rd_reg(3'(r), rd);
            chk("R1 register", rd, 32'd0);
        end

        // R2 program and read back
        wr_reg(3'd0, 32'h0000_1000);
        wr_reg(3'd1, 32'h2000_0004);
        wr_reg(3'd2, 32'h0000_0080);
        wr_reg(3'd3, 32'h2000_0006);
        wr_reg(3'd4, 32'h72D0_0059);
        rd_reg(3'd1, rd); chk("R2 addr1", rd, 32'h2000_0004);
        rd_reg(3'd4, rd); chk("R2 ctrl", rd, 32'h72D0_0059);
        rd_reg(3'd6, rd); chk("R2 unused", rd, 32'd0);

        // table of single accesses
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] exp;
            exp = VEC[v][3:0];
            access(VEC[v][39:37], VEC[v][36:5], VEC[v][4], 1'b0, 1'b0);
            chk("R9 dbg_req", {31'd0, dbg_req}, {31'd0, (exp != 4'd0)});
            chk("R10 hit_mask", {28'd0, hit_mask}, {28'd0, exp});
            if (exp != 4'd0) chk("R9 vector", {24'd0, dbg_vector}, 32'd1);
            rd_reg(3'd5, rd); chk("R12 status", rd, {28'd0, exp});
            @(negedge clk);
            chk("R9 single pulse", {31'd0, dbg_req}, 32'd0);
            wr_reg(3'd5, 32'd0);
        end

        // R3 enables: drop local enable of bp0, then use global only
        wr_reg(3'd4, 32'h72D0_0058);
        access(3'd0, 32'h0000_1000, 1'b1, 1'b0, 1'b0);
        chk("R3 disabled", {31'd0, dbg_req}, 32'd0);
        wr_reg(3'd4, 32'h72D0_005A);
        access(3'd0, 32'h0000_1000, 1'b1, 1'b0, 1'b0);
        chk("R3 global enable", {28'd0, hit_mask}, 32'h1);
        @(negedge clk);
        wr_reg(3'd5, 32'd0);

        // R6 length 2'b10 behaves as four bytes: bp1 len 10
        wr_reg(3'd4, 32'h7290_0059);
        access(3'd2, 32'h2000_0006, 1'b1, 1'b0, 1'b0);
        chk("R6 len10 four bytes", {28'd0, hit_mask}, 32'b1010);
        @(negedge clk);
        // R6 length 00 on bp1: exact byte only
        wr_reg(3'd4, 32'h7210_0059);
        access(3'd2, 32'h2000_0005, 1'b1, 1'b0, 1'b0);
        chk("R6 len00 exact", {31'd0, dbg_req}, 32'd0);
        wr_reg(3'd4, 32'h72D0_0059);
        wr_reg(3'd5, 32'd0);

        // R12 sticky accumulation and clear
        access(3'd0, 32'h0000_1000, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        access(3'd3, 32'h0000_0080, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rd_reg(3'd5, rd); chk("R12 accumulate", rd, 32'b0101);
        wr_reg(3'd5, 32'b0100);
        rd_reg(3'd5, rd); chk("R12 partial clear", rd, 32'b0100);
        wr_reg(3'd5, 32'd0);
        rd_reg(3'd5, rd); chk("R12 clear", rd, 32'd0);

        // R11 deferred hit, merged with a second hit, then done
        access(3'd1, 32'h2000_0006, 1'b1, 1'b1, 1'b0);
        chk("R11 held", {31'd0, dbg_req}, 32'd0);
        @(negedge clk);
        chk("R11 still held", {31'd0, dbg_req}, 32'd0);
        rd_reg(3'd5, rd); chk("R11 status waits", rd, 32'd0);
        access(3'd2, 32'h2000_0004, 1'b1, 1'b1, 1'b0);
        chk("R11 held after merge", {31'd0, dbg_req}, 32'd0);
        acc_iter_done = 1'b1;
        @(negedge clk);
        acc_iter_done = 1'b0;
        chk("R11 fire after done", {31'd0, dbg_req}, 32'd1);
        chk("R11 merged mask", {28'd0, hit_mask}, 32'b1010);
        @(negedge clk);
        chk("R11 pulse ends", {31'd0, dbg_req}, 32'd0);
        acc_rep = 1'b0;
        wr_reg(3'd5, 32'd0);

        // R11 hit in the cycle its iteration ends
        access(3'd0, 32'h0000_1000, 1'b1, 1'b1, 1'b1);
        chk("R11 same-cycle done", {28'd0, hit_mask}, 32'b0001);
        acc_rep = 1'b0;
        @(negedge clk);

        // R12 hit wins over a same-edge clear
        reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'd0;
        access(3'd3, 32'h0000_0080, 1'b1, 1'b0, 1'b0);
        reg_wr = 1'b0;
        rd_reg(3'd5, rd); chk("R12 hit ORed into write", rd, 32'b0100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule